// File: doc/BRIEF.md
# Sequential Significand Divider

This block divides one normalized floating-point significand by another. Both operands are unsigned fixed-point values in [1.0, 2.0) with the hidden bit at the top. One quotient bit is produced per clock, most significant first, using a shift-and-subtract loop. The non-negative test for each step is the sign bit of a difference that is one bit wider than the doubled remainder, so no separate magnitude comparator is needed. Before the loop starts, a normalization step compares X with Y once. When X < Y, the remainder starts at X instead of X - Y and one more step is run, so the quotient's top bit is always 1. In that case the result exponent is reduced by one.

The quotient carries the significand bits plus a configurable number of extra low bits (two by default, the guard and round positions). A sticky flag reports whether the final remainder is nonzero, which means the true quotient has further 1 bits below the last position produced. The loop always runs its full length, even when the remainder reaches zero early. Operand classification, sign handling, rounding and packing belong to the surrounding datapath.

A one-cycle start strobe loads the operands when the unit is idle. Busy stays high while steps remain. Done pulses for one cycle when the quotient, exponent and sticky flag are all valid.

Top module: `mdiv_core`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, quo_o, exp_o and sticky_o are all zero.
- R2: A start_i pulse seen while idle loads the operands, and busy_o is high in the cycle after that clock edge.
- R3: When x_i >= y_i, quo_o equals floor(x_i * 2^(QW-1) / y_i), where QW = MANT_W + GR_BITS. exp_o equals ex_i - ey_i, as a two's-complement value one bit wider than the exponent inputs.
- R4: When x_i < y_i, quo_o equals floor(2 * x_i * 2^(QW-1) / y_i) and exp_o equals ex_i - ey_i - 1, in the same wider two's-complement form.
- R5: Bit QW-1 of quo_o is 1 on every result.
- R6: sticky_o is 1 exactly when the division leaves a nonzero remainder. An exact quotient such as 1.5 / 1.0 gives 0, and 1.0 / 1.5 gives 1.
- R7: done_o is high for exactly one cycle. It rises QW-1 clock edges after the accepting edge when x_i >= y_i, and QW edges after it when x_i < y_i. busy_o is low whenever done_o is high.
- R8: A start_i pulse while busy_o is high is ignored, and the running division finishes with its original result.
- R9: After done_o, quo_o, exp_o and sticky_o keep their values until the next accepted start.
- R10: When x_i equals y_i, quo_o is exactly 2^(QW-1), sticky_o is 0 and exp_o is ex_i - ey_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a division |
| x_i | input | MANT_W | Dividend significand, top bit is the hidden 1 |
| y_i | input | MANT_W | Divisor significand, top bit is the hidden 1 |
| ex_i | input | EXP_W | Dividend exponent, two's complement, unbiased |
| ey_i | input | EXP_W | Divisor exponent, two's complement, unbiased |
| busy_o | output | 1 | High while quotient bits remain to be produced |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| quo_o | output | MANT_W+GR_BITS | Quotient significand with the extra low bits |
| exp_o | output | EXP_W+1 | Result exponent, two's complement |
| sticky_o | output | 1 | Final remainder is nonzero |

## Verification
The result is due at a latency that depends on the operand order. done_o rises QW-1 edges after the accepting edge when X >= Y and QW edges after it when X < Y. Quotient, exponent and sticky are read in that same cycle. The driver stamps each expected item with the cycle its start strobe was set and with the latency the operand order calls for. The monitor samples on the falling edge and checks that the done pulse lands exactly on that cycle, so an early, late or extra done is reported. The hold and ignored-start checks read the ports a few cycles after done and compare them with the last expected item.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mdiv_state_e;

endpackage

// File: rtl/mdiv_prenorm.sv
// Normalization pre-step: one trial subtraction X - Y picks the starting
// remainder, the first quotient bit and the exponent adjustment.
module mdiv_prenorm #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10
) (
  input  logic [MANT_W-1:0] x_i,
  input  logic [MANT_W-1:0] y_i,
  input  logic [EXP_W-1:0]  ex_i,
  input  logic [EXP_W-1:0]  ey_i,
  output logic [MANT_W:0]   rem_o,
  output logic              qbit_o,
  output logic [EXP_W:0]    exp_o
);

  logic [MANT_W+1:0] diff;
  logic              nonneg;
  logic [EXP_W:0]    ex_w;
  logic [EXP_W:0]    ey_w;

  always_comb begin
    diff   = {2'b00, x_i} - {2'b00, y_i};
    nonneg = ~diff[MANT_W+1];
    // X >= Y: keep the difference; X < Y: keep X, the loop doubles it first
    rem_o  = nonneg ? diff[MANT_W:0] : {1'b0, x_i};
    qbit_o = nonneg;
    ex_w   = {ex_i[EXP_W-1], ex_i};
    ey_w   = {ey_i[EXP_W-1], ey_i};
    exp_o  = ex_w - ey_w - {{EXP_W{1'b0}}, ~nonneg};
  end

endmodule

// File: rtl/mdiv_step.sv
// One restoring iteration: double the remainder, trial-subtract the divisor,
// and decide the quotient bit from the sign of the difference.
module mdiv_step #(
  parameter int MANT_W = 24
) (
  input  logic [MANT_W:0]   rem_i,
  input  logic [MANT_W-1:0] y_i,
  output logic [MANT_W:0]   rem_o,
  output logic              qbit_o
);

  logic [MANT_W+1:0] dbl;
  logic [MANT_W+1:0] diff;

  always_comb begin
    dbl    = {rem_i, 1'b0};
    diff   = dbl - {2'b00, y_i};
    qbit_o = ~diff[MANT_W+1];
    rem_o  = qbit_o ? diff[MANT_W:0] : dbl[MANT_W:0];
  end

endmodule

// File: rtl/mdiv_core.sv
module mdiv_core #(
  parameter int MANT_W  = 24,
  parameter int EXP_W   = 10,
  parameter int GR_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [MANT_W-1:0]         x_i,
  input  logic [MANT_W-1:0]         y_i,
  input  logic [EXP_W-1:0]          ex_i,
  input  logic [EXP_W-1:0]          ey_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [MANT_W+GR_BITS-1:0] quo_o,
  output logic [EXP_W:0]            exp_o,
  output logic                      sticky_o
);
  import mdiv_pkg::*;

  localparam int QW    = MANT_W + GR_BITS;
  localparam int CNT_W = $clog2(QW + 1);

  mdiv_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MANT_W:0]   rem_q;
  logic [MANT_W-1:0] y_q;
  logic [QW-1:0]     quo_q;
  logic [EXP_W:0]    exp_q;
  logic              sticky_q;
  logic              done_q;

  logic [MANT_W:0]   pre_rem;
  logic              pre_q;
  logic [EXP_W:0]    pre_exp;
  logic [MANT_W:0]   st_rem;
  logic              st_q;

  mdiv_prenorm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_pre (
    .x_i    (x_i),
    .y_i    (y_i),
    .ex_i   (ex_i),
    .ey_i   (ey_i),
    .rem_o  (pre_rem),
    .qbit_o (pre_q),
    .exp_o  (pre_exp)
  );

  mdiv_step #(.MANT_W(MANT_W)) u_step (
    .rem_i  (rem_q),
    .y_i    (y_q),
    .rem_o  (st_rem),
    .qbit_o (st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rem_q    <= '0;
      y_q      <= '0;
      quo_q    <= '0;
      exp_q    <= '0;
      sticky_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            y_q      <= y_i;
            rem_q    <= pre_rem;
            quo_q    <= {{(QW-1){1'b0}}, pre_q};
            exp_q    <= pre_exp;
            sticky_q <= 1'b0;
            // a set leading bit already covers one position
            cnt_q    <= pre_q ? CNT_W'(QW - 1) : CNT_W'(QW);
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q <= st_rem;
          quo_q <= {quo_q[QW-2:0], st_q};
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            sticky_q <= |st_rem;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign quo_o    = quo_q;
  assign exp_o    = exp_q;
  assign sticky_o = sticky_q;

  // R5: the normalized quotient always carries its leading one
  p_lead_one_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> quo_q[QW-1]);

  // R7: done is a single-cycle pulse and never overlaps busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == ST_IDLE));

  // R3: partial remainder stays below the divisor while iterating
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (rem_q < {1'b0, y_q}));

  // R8: a start strobe during a run neither ends nor reloads it
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && (cnt_q > CNT_W'(1))) |=>
      ((state_q == ST_RUN) && $stable(y_q) && $stable(exp_q)));

  // R9: results are frozen while idle without a start
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !start_i) |=>
      ($stable(quo_q) && $stable(exp_q) && $stable(sticky_q)));

endmodule

// File: tb/test_mdiv_core.sv
module test_mdiv_core;

  localparam int MW = 24;
  localparam int EW = 10;
  localparam int GR = 2;
  localparam int QW = MW + GR;

  typedef struct {
    logic [QW-1:0] q;
    logic [EW:0]   e;
    logic          s;
    int            lat;
    int            t0;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [MW-1:0] x_i = '0;
  logic [MW-1:0] y_i = '0;
  logic [EW-1:0] ex_i = '0;
  logic [EW-1:0] ey_i = '0;
  logic          busy_o;
  logic          done_o;
  logic [QW-1:0] quo_o;
  logic [EW:0]   exp_o;
  logic          sticky_o;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  item_t sb[$];
  item_t last;

  mdiv_core #(.MANT_W(MW), .EXP_W(EW), .GR_BITS(GR)) i_mdiv_core (
    .clk(clk), .rst(rst), .start_i(start_i), .x_i(x_i), .y_i(y_i),
    .ex_i(ex_i), .ey_i(ey_i), .busy_o(busy_o), .done_o(done_o),
    .quo_o(quo_o), .exp_o(exp_o), .sticky_o(sticky_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic item_t model(input logic [MW-1:0] x, input logic [MW-1:0] y,
                                  input int ex, input int ey, input string tag);
    item_t it;
    longint unsigned num;
    num    = (x >= y) ? longint'(x) : 2 * longint'(x);
    num    = num << (QW - 1);
    it.q   = QW'(num / longint'(y));
    it.s   = (num % longint'(y)) != 0;
    it.e   = (EW+1)'(ex - ey - ((x < y) ? 1 : 0));
    it.lat = (x >= y) ? QW - 1 : QW;
    it.t0  = 0;
    it.tag = tag;
    return it;
  endfunction

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " quotient"}, quo_o, it.q);
        check({it.tag, " exponent"}, exp_o, it.e);
        check({it.tag, "/R6 sticky"}, sticky_o, it.s);
        check({it.tag, "/R5 lead bit"}, quo_o[QW-1], 1);
        check({it.tag, "/R7 latency"}, cyc - it.t0, it.lat + 1);
        check({it.tag, "/R7 busy low at done"}, busy_o, 0);
      end
    end
  end

  task automatic run(input logic [MW-1:0] x, input logic [MW-1:0] y,
                     input int ex, input int ey, input string tag, input bit poke);
    item_t it;
    it = model(x, y, ex, ey, tag);
    @(negedge clk);
    x_i = x; y_i = y; ex_i = EW'(ex); ey_i = EW'(ey);
    start_i = 1'b1;
    it.t0 = cyc;
    sb.push_back(it);
    last = it;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", busy_o, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      x_i = ~x | (MW'(1) << (MW - 1)); y_i = (MW'(1) << (MW - 1)) | MW'(5);
      ex_i = EW'(7); ey_i = EW'(-3);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R8 still busy after ignored start", busy_o, 1);
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic check_hold(input string req);
    repeat (4) @(negedge clk);
    check({req, " quotient held"}, quo_o, last.q);
    check({req, " exponent held"}, exp_o, last.e);
    check({req, " sticky held"}, sticky_o, last.s);
    check({req, " no extra done"}, done_o, 0);
  endtask

  function automatic logic [MW-1:0] rnd_mant();
    return (MW'(1) << (MW - 1)) | MW'($urandom() & ((1 << (MW - 1)) - 1));
  endfunction

  localparam logic [MW-1:0] ONE  = MW'(1) << (MW - 1);
  localparam logic [MW-1:0] ONE5 = MW'(3) << (MW - 2);
  localparam logic [MW-1:0] MAXM = {MW{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 quotient", quo_o, 0);
    check("R1 exponent", exp_o, 0);
    check("R1 sticky", sticky_o, 0);

    run(ONE5, ONE, 3, 1, "R3 exact 1.5/1", 0);
    run(ONE, ONE5, 0, 0, "R4 1/1.5", 0);
    run(ONE5, ONE5, 5, 9, "R10 equal", 0);
    check_hold("R9");
    run(MAXM, ONE, 511, -512, "R3 max/1 exp top", 0);
    run(ONE, MAXM, -512, 511, "R4 1/max exp bottom", 0);
    run(ONE5, ONE5 + MW'(1), 2, 2, "R4 just below", 0);
    run(ONE5 + MW'(1), ONE5, 2, 2, "R3 just above", 0);
    run(rnd_mant(), rnd_mant(), 10, -4, "R8 poked", 1);
    check_hold("R8/R9");

    for (int i = 0; i < 40; i++) begin
      logic [MW-1:0] a;
      logic [MW-1:0] b;
      a = rnd_mant();
      b = (i % 5 == 0) ? a : rnd_mant();
      if (i % 7 == 3) b = a + MW'(1);
      if (b < ONE) b = ONE;
      run(a, b, int'($urandom_range(400)) - 200, int'($urandom_range(400)) - 200,
          (a == b) ? "R10 random" : ((a >= b) ? "R3 random" : "R4 random"), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule